// File: doc/BRIEF.md
# Sum-Addressed Word-Line Decoder

This block selects one word line of a memory array from a base value and an offset without first adding the two in a carry-propagating adder. Each row carries its own constant row number L. It checks whether base + offset + ~L is all ones inside the index field, which holds exactly when the index of the sum equals L. The three operands are reduced per bit to a sum and a carry in carry-save form. The row matches when every sum bit is the complement of the carry bit beside it, so no carry has to ripple across the field.

For each index bit only four shared match terms exist. They are chosen by the row's bit at that position and the row's bit one position lower. The two terms for a row bit of 1 are the inverses of the two for a row bit of 0. Every row takes one term per bit and ANDs them together. The carry out of the byte-offset bits below the field is folded into the lowest term. A carry out of the top of the field is dropped. A plainly added reference sum is driven beside the word lines so the decode can be checked against it. The block is purely combinational.

Top module: `sum_addr_decoder`

## Requirements
- R1: With default parameters the index field is sum bits [13:3], giving 2048 word lines; wordline_o[k] belongs to index value k.
- R2: For every pair of operands exactly one bit of wordline_o is 1.
- R3: The asserted line is the one whose number equals bits [13:3] of base_i + offs_i.
- R4: A carry out of base_i[2:0] + offs_i[2:0] moves the selection to the next line (for example 7 + 1 selects line 1).
- R5: A carry out of bit 13 of the sum is dropped, so the line number wraps modulo 2048 (0x3FF8 + 8 and 0xFFFFFFFF + 1 both select line 0).
- R6: Operand bits above bit 13 have no effect on which line is asserted.
- R7: ref_sum_o equals base_i + offs_i modulo 2^32.
- R8: With offs_i equal to zero, the asserted line is base_i[13:3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base_i | input | 32 | Base register value |
| offs_i | input | 32 | Offset added to the base |
| wordline_o | output | 2048 | One-hot word-line vector, bit k for index k |
| ref_sum_o | output | 32 | Separately added full-width sum for checking |

## Verification
The checker asserts, whenever its inputs change, that the word-line vector is one-hot, that the asserted bit sits at the index taken from the separately added reference sum, that a zero offset selects the base's own index, and that line 0 is raised exactly when that index is zero. The bench's scenarios show what those relations cannot show on their own. These are the reference sum against an independent addition, the wrap of sums that leave the field, the low-bit carry that steps to the next line, and the indifference to high operand bits.

// File: rtl/sad_pkg.sv
`timescale 1ns/1ps
package sad_pkg;

    localparam int SAD_ADDR_W  = 32;
    localparam int SAD_IDX_LSB = 3;
    localparam int SAD_IDX_W   = 11;

    // Number of shared terms driven per index bit: (row bit, lower row bit).
    localparam int SAD_TERMS_PER_BIT = 4;

    // Carry produced by a full adder whose third input is the constant
    // inverted row bit k: the majority degenerates to AND (k=0) or OR (k=1).
    function automatic logic sad_carry(input logic r, input logic o, input logic k);
        return k ? (r | o) : (r & o);
    endfunction

    // Match term: sum bit xor incoming carry; 1 means "complementary".
    function automatic logic sad_term(input logic r, input logic o,
                                      input logic k, input logic cin);
        return r ^ o ^ k ^ cin;
    endfunction

endpackage

// File: rtl/sad_low_carry.sv
`timescale 1ns/1ps
module sad_low_carry #(
    parameter int LOW_W = 3
) (
    input  logic [(LOW_W > 0 ? LOW_W : 1)-1:0] base_low,
    input  logic [(LOW_W > 0 ? LOW_W : 1)-1:0] offs_low,
    output logic                               carry_o
);
    generate
        if (LOW_W == 0) begin : g_none
            logic unused_low;
            assign unused_low = ^{base_low, offs_low};
            assign carry_o    = 1'b0;
        end else begin : g_add
            logic [LOW_W:0] low_sum;
            assign low_sum = {1'b0, base_low} + {1'b0, offs_low};
            assign carry_o = low_sum[LOW_W];
        end
    endgenerate
endmodule

// File: rtl/sad_term_gen.sv
`timescale 1ns/1ps
module sad_term_gen
    import sad_pkg::*;
#(
    parameter int IDX_W = 11
) (
    input  logic [IDX_W-1:0]                   base_fld,
    input  logic [IDX_W-1:0]                   offs_fld,
    input  logic                               low_carry,
    // Term index: bit*4 + k_cur*2 + k_low, with k = inverted row bit.
    output logic [IDX_W*SAD_TERMS_PER_BIT-1:0] terms_o
);
    for (genvar b = 0; b < IDX_W; b++) begin : g_bit
        for (genvar kl = 0; kl < 2; kl++) begin : g_low
            logic term_k0;
            if (b == 0) begin : g_lsb
                // The carry from the byte-offset bits enters here.
                assign term_k0 = sad_term(base_fld[0], offs_fld[0], 1'b0, low_carry);
            end else begin : g_upper
                logic cin;
                assign cin     = sad_carry(base_fld[b-1], offs_fld[b-1], kl[0]);
                assign term_k0 = sad_term(base_fld[b], offs_fld[b], 1'b0, cin);
            end
            // Row-bit inversion of the sum simply inverts the term.
            assign terms_o[b*SAD_TERMS_PER_BIT + 0 + kl] = term_k0;
            assign terms_o[b*SAD_TERMS_PER_BIT + 2 + kl] = ~term_k0;
        end
    end
endmodule

// File: rtl/sad_row_array.sv
`timescale 1ns/1ps
module sad_row_array
    import sad_pkg::*;
#(
    parameter int IDX_W = 11,
    localparam int LINES = 1 << IDX_W
) (
    input  logic [IDX_W*SAD_TERMS_PER_BIT-1:0] terms_i,
    output logic [LINES-1:0]                   wordline_o
);
    for (genvar row = 0; row < LINES; row++) begin : g_row
        logic [IDX_W-1:0] hit;
        for (genvar b = 0; b < IDX_W; b++) begin : g_sel
            localparam int KC  = ((row >> b) & 1) == 0 ? 1 : 0;
            localparam int KL  = (b == 0) ? 0 : ((((row >> (b-1)) & 1) == 0) ? 1 : 0);
            localparam int SEL = b*SAD_TERMS_PER_BIT + KC*2 + KL;
            assign hit[b] = terms_i[SEL];
        end
        assign wordline_o[row] = &hit;
    end
endmodule

// File: rtl/sum_addr_decoder.sv
`timescale 1ns/1ps
module sum_addr_decoder
    import sad_pkg::*;
#(
    parameter int ADDR_W  = SAD_ADDR_W,
    parameter int IDX_LSB = SAD_IDX_LSB,
    parameter int IDX_W   = SAD_IDX_W,
    localparam int LINES  = 1 << IDX_W,
    localparam int LOW_PW = (IDX_LSB > 0) ? IDX_LSB : 1
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] offs_i,
    output logic [LINES-1:0]  wordline_o,
    output logic [ADDR_W-1:0] ref_sum_o
);
    logic [LOW_PW-1:0]                   base_low;
    logic [LOW_PW-1:0]                   offs_low;
    logic                                low_carry;
    logic [IDX_W*SAD_TERMS_PER_BIT-1:0]  terms;

    generate
        if (IDX_LSB > 0) begin : g_low
            assign base_low = base_i[IDX_LSB-1:0];
            assign offs_low = offs_i[IDX_LSB-1:0];
        end else begin : g_nolow
            assign base_low = '0;
            assign offs_low = '0;
        end
    endgenerate

    sad_low_carry #(.LOW_W(IDX_LSB)) i_low (
        .base_low (base_low),
        .offs_low (offs_low),
        .carry_o  (low_carry)
    );

    sad_term_gen #(.IDX_W(IDX_W)) i_terms (
        .base_fld  (base_i[IDX_LSB +: IDX_W]),
        .offs_fld  (offs_i[IDX_LSB +: IDX_W]),
        .low_carry (low_carry),
        .terms_o   (terms)
    );

    sad_row_array #(.IDX_W(IDX_W)) i_rows (
        .terms_i    (terms),
        .wordline_o (wordline_o)
    );

    // Plain adder kept apart from the decode path, for checking only.
    assign ref_sum_o = base_i + offs_i;
endmodule

// File: rtl/sad_checker.sv
`timescale 1ns/1ps
module sad_checker #(
    parameter int ADDR_W  = 32,
    parameter int IDX_LSB = 3,
    parameter int IDX_W   = 11,
    localparam int LINES  = 1 << IDX_W
) (
    input logic [ADDR_W-1:0] base_i,
    input logic [ADDR_W-1:0] offs_i,
    input logic [LINES-1:0]  wordline_o,
    input logic [ADDR_W-1:0] ref_sum_o
);
    logic [IDX_W-1:0] ref_idx;
    logic [IDX_W-1:0] base_idx;
    assign ref_idx  = ref_sum_o[IDX_LSB +: IDX_W];
    assign base_idx = base_i[IDX_LSB +: IDX_W];

    always_comb begin
        // R2: exactly one hot line
        p_onehot_r2: assert ($countones(wordline_o) == 1)
            else $error("R2 word lines not one-hot");
        // R3: hot line sits at the index of the reference sum
        p_line_matches_sum_r3: assert (wordline_o[ref_idx])
            else $error("R3 word line differs from reference index");
        // R8: zero offset selects the base index
        p_zero_offset_r8: assert (offs_i != '0 || wordline_o[base_idx])
            else $error("R8 zero offset did not select base index");
        // R1: line 0 raised exactly when the index is zero
        p_line_zero_r1: assert (wordline_o[0] == (ref_idx == '0))
            else $error("R1 line 0 mismatch");
    end
endmodule

bind sum_addr_decoder sad_checker #(
    .ADDR_W  (ADDR_W),
    .IDX_LSB (IDX_LSB),
    .IDX_W   (IDX_W)
) i_sad_checker (
    .base_i     (base_i),
    .offs_i     (offs_i),
    .wordline_o (wordline_o),
    .ref_sum_o  (ref_sum_o)
);

// File: tb/test_sum_addr_decoder.sv
`timescale 1ns/1ps
module test_sum_addr_decoder;

    localparam int AW    = 32;
    localparam int LSB   = 3;
    localparam int IW    = 11;
    localparam int LINES = 1 << IW;

    typedef struct {
        int unsigned exp_line;
        logic [AW-1:0] exp_sum;
        string         tag;
    } item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   base_i = '0;
    logic [AW-1:0]   offs_i = '0;
    logic [LINES-1:0] wordline_o;
    logic [AW-1:0]   ref_sum_o;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sum_addr_decoder i_sum_addr_decoder (
        .base_i     (base_i),
        .offs_i     (offs_i),
        .wordline_o (wordline_o),
        .ref_sum_o  (ref_sum_o)
    );

    task automatic drive(input logic [AW-1:0] r, input logic [AW-1:0] o, input string tag);
        item_t it;
        logic [63:0] wide;
        @(posedge clk);
        base_i = r;
        offs_i = o;
        wide = {32'd0, r} + {32'd0, o};
        it.exp_sum  = wide[AW-1:0];
        it.exp_line = int'((wide >> LSB) & 64'(LINES - 1));
        it.tag      = tag;
        q.push_back(it);
    endtask

    // Monitor: compare the settled outputs half a cycle later.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && q.size() > 0) begin
                item_t it;
                int first;
                it = q.pop_front();
                first = -1;
                for (int k = LINES - 1; k >= 0; k--) if (wordline_o[k]) first = k;
                checks++;
                if ($countones(wordline_o) != 1 || first != int'(it.exp_line)) begin
                    errors++;
                    $display("FAIL %s: hot=%0d line=%0d expected line %0d",
                             it.tag, $countones(wordline_o), first, it.exp_line);
                end
                checks++;
                if (ref_sum_o !== it.exp_sum) begin
                    errors++;
                    $display("FAIL R7: ref_sum=%h expected %h", ref_sum_o, it.exp_sum);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        drive(32'h0, 32'h0, "R1 reset state");
        drive(32'h0000_2008, 32'h0, "R1 line 1025");
        drive(32'h0000_3FF8, 32'h0, "R1 top line");
        drive(32'h7, 32'h1, "R4 low carry");
        drive(32'h5, 32'h4, "R4 low carry mid");
        drive(32'h0000_00F3, 32'h0000_0006, "R4 carry into field");
        drive(32'h0000_3FF8, 32'h8, "R5 field wrap");
        drive(32'hFFFF_FFFF, 32'h1, "R5 all ones plus one");
        drive(32'h0000_3FFF, 32'h0000_3FFF, "R5 double wrap");
        drive(32'h0000_0018, 32'h0, "R6 base low");
        drive(32'hFFFF_0018, 32'h0, "R6 high bits set");
        drive(32'h0000_0018, 32'h5A5A_0000, "R6 high offset bits");
        drive(32'h1234_5678, 32'h0, "R8 zero offset");
        drive(32'hFFFF_FFF8, 32'hFFFF_FFF8, "R7 full wrap");
        for (int n = 0; n < 300; n++) drive($urandom, $urandom, "R3 random");
        for (int n = 0; n < 50; n++) drive($urandom, 32'h0, "R8 random base");
        for (int n = 0; n < 50; n++) drive($urandom, -($urandom & 32'hFF), "R3 negative offset");
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule